// File: doc/BRIEF.md
# Data Address Watchpoint Unit

This block watches the data side of a processor for accesses to one programmed address. Every load and store presented on the data access bus is compared, at word granularity, against a watch address register. Two independent enable bits select whether loads, stores or both may fire the watchpoint. When an access of an enabled direction touches the watched word, the block raises a one-cycle trap request, records the address of the instruction that made the access, and sets a sticky data-access-trap status bit.

The watch address and the enable bits are written through a small register port that carries a privilege flag. Only supervisor writes take effect. A write made in user mode changes nothing and produces a one-cycle privilege-violation pulse. Software clears the sticky status bit through the same port. Trap vectoring and pipeline flushing are left to the surrounding core.

Top module: `dwatch_top`

## Requirements
- R1: After reset, the watch address, both enables, the trap request, the status bit, the captured instruction address and the privilege-violation output are all zero.
- R2: A supervisor write (cfg_we=1, cfg_super=1) with cfg_sel=0 loads cfg_wdata into the watch address. With cfg_sel=1 it loads the read enable from cfg_wdata bit 0 and the write enable from bit 1. Both are visible on the outputs one cycle later.
- R3: A valid load (acc_valid=1, acc_write=0) whose address bits [31:2] equal those of the watch address, with the read enable set, drives trap_o high for exactly the following cycle. Address bits [1:0] take no part in the comparison.
- R4: A valid store (acc_valid=1, acc_write=1) that matches in the same way, with the write enable set, drives trap_o high for exactly the following cycle.
- R5: No trap occurs for an access with acc_valid=0, for an access in a different word, for an access whose direction enable is clear, or for any access while both enables are clear.
- R6: When a trap fires, fault_pc_o takes the acc_pc of the matching access in the same cycle that trap_o rises. At all other times it holds its value.
- R7: The status bit sets together with every trap. It then stays set until a supervisor control write (cfg_sel=1) with cfg_wdata bit 2 set. If a trap and a clear fall in the same cycle, the status bit ends up set.
- R8: A write with cfg_we=1 and cfg_super=0 leaves the watch address, the enables and the status bit unchanged, and drives priv_viol_o high for exactly the following cycle.
- R9: The comparison uses the register values from before the current cycle. A configuration write in the same cycle as an access affects only later accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 watch address, 1 control |
| cfg_super | input | 1 | Writer is at supervisor level |
| cfg_wdata | input | 32 | Write data |
| acc_valid | input | 1 | Data access present this cycle |
| acc_write | input | 1 | Access is a store (1) or a load (0) |
| acc_addr | input | 32 | Data address of the access |
| acc_pc | input | 32 | Address of the instruction making the access |
| watch_addr_o | output | 32 | Current watch address |
| rd_en_o | output | 1 | Load watch enable |
| wr_en_o | output | 1 | Store watch enable |
| trap_o | output | 1 | One-cycle trap request |
| trap_sts_o | output | 1 | Sticky data-access-trap status |
| fault_pc_o | output | 32 | Instruction address captured at the last trap |
| priv_viol_o | output | 1 | One-cycle pulse after an ignored user-mode write |

## Verification
The hardest case to reach from the ports is a trap and a status clear landing in the same cycle, together with a configuration write that coincides with an access. Both need the register port and the access bus to be driven on the same edge. The directed tests after the vector table do exactly that: a matching store is driven alongside a supervisor clear, and an enable write is driven alongside a matching load. The checks then confirm that the status bit stays set and that the old enables decided the outcome. Ignored user-mode writes are checked through the configuration outputs and through an access that would trap only if the write had taken effect.

// File: rtl/dwatch_pkg.sv
package dwatch_pkg;
  typedef enum logic {
    SEL_WATCH = 1'b0,
    SEL_CTRL  = 1'b1
  } cfg_sel_e;

  localparam int CTRL_RD_BIT  = 0;
  localparam int CTRL_WR_BIT  = 1;
  localparam int CTRL_CLR_BIT = 2;

  typedef struct packed {
    logic rd_en;
    logic wr_en;
  } dir_en_t;
endpackage

// File: rtl/dwatch_cfg.sv
module dwatch_cfg #(
  parameter int ADDR_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_we,
  input  logic                  cfg_sel,
  input  logic                  cfg_super,
  input  logic [ADDR_W-1:0]     cfg_wdata,
  output logic [ADDR_W-1:0]     watch_addr,
  output dwatch_pkg::dir_en_t   dir_en,
  output logic                  clr_req,
  output logic                  priv_viol
);
  import dwatch_pkg::*;

  logic wr_ok, wr_bad;
  assign wr_ok  = cfg_we && cfg_super;
  assign wr_bad = cfg_we && !cfg_super;
  assign clr_req = wr_ok && (cfg_sel == SEL_CTRL) && cfg_wdata[CTRL_CLR_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      watch_addr <= '0;
      dir_en     <= '0;
      priv_viol  <= 1'b0;
    end else begin
      priv_viol <= wr_bad;
      if (wr_ok && cfg_sel == SEL_WATCH)
        watch_addr <= cfg_wdata;
      if (wr_ok && cfg_sel == SEL_CTRL) begin
        dir_en.rd_en <= cfg_wdata[CTRL_RD_BIT];
        dir_en.wr_en <= cfg_wdata[CTRL_WR_BIT];
      end
    end
  end

  // R8
  user_wr_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    $past(wr_bad) && !$past(rst) |-> $stable(watch_addr) && $stable(dir_en));

  // R8
  priv_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    priv_viol |-> $past(cfg_we) && !$past(cfg_super));
endmodule

// File: rtl/dwatch_match.sv
module dwatch_match #(
  parameter int ADDR_W    = 32,
  parameter int GRAN_BITS = 2
) (
  input  logic                 acc_valid,
  input  logic                 acc_write,
  input  logic [ADDR_W-1:0]    acc_addr,
  input  logic [ADDR_W-1:0]    watch_addr,
  input  dwatch_pkg::dir_en_t  dir_en,
  output logic                 hit
);
  localparam int CMP_W = ADDR_W - GRAN_BITS;

  logic             word_eq;
  logic             dir_ok;
  logic [GRAN_BITS-1:0] unused_low;

  assign unused_low = acc_addr[GRAN_BITS-1:0] ^ watch_addr[GRAN_BITS-1:0];
  assign word_eq = (acc_addr[ADDR_W-1 -: CMP_W] == watch_addr[ADDR_W-1 -: CMP_W]);
  assign dir_ok  = acc_write ? dir_en.wr_en : dir_en.rd_en;
  assign hit     = acc_valid && word_eq && dir_ok;
endmodule

// File: rtl/dwatch_capture.sv
module dwatch_capture #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  input  logic              clr_req,
  input  logic [ADDR_W-1:0] acc_pc,
  output logic              trap,
  output logic              trap_sts,
  output logic [ADDR_W-1:0] fault_pc
);
  always_ff @(posedge clk) begin
    if (rst) begin
      trap     <= 1'b0;
      trap_sts <= 1'b0;
      fault_pc <= '0;
    end else begin
      trap <= hit;
      if (hit) begin
        fault_pc <= acc_pc;
        trap_sts <= 1'b1;
      end else if (clr_req) begin
        trap_sts <= 1'b0;
      end
    end
  end

  // R7
  sts_with_trap_chk: assert property (@(posedge clk) disable iff (rst)
    trap |-> trap_sts);

  // R6
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !trap && !$past(rst) |-> $stable(fault_pc));

  // R7
  sts_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(trap_sts) |-> $past(clr_req));
endmodule

// File: rtl/dwatch_top.sv
module dwatch_top #(
  parameter int ADDR_W    = 32,
  parameter int GRAN_BITS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic              cfg_super,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [ADDR_W-1:0] acc_pc,
  output logic [ADDR_W-1:0] watch_addr_o,
  output logic              rd_en_o,
  output logic              wr_en_o,
  output logic              trap_o,
  output logic              trap_sts_o,
  output logic [ADDR_W-1:0] fault_pc_o,
  output logic              priv_viol_o
);
  import dwatch_pkg::*;

  dir_en_t dir_en;
  logic    clr_req;
  logic    hit;

  dwatch_cfg #(.ADDR_W(ADDR_W)) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .cfg_super  (cfg_super),
    .cfg_wdata  (cfg_wdata),
    .watch_addr (watch_addr_o),
    .dir_en     (dir_en),
    .clr_req    (clr_req),
    .priv_viol  (priv_viol_o)
  );

  dwatch_match #(.ADDR_W(ADDR_W), .GRAN_BITS(GRAN_BITS)) u_match (
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .acc_addr   (acc_addr),
    .watch_addr (watch_addr_o),
    .dir_en     (dir_en),
    .hit        (hit)
  );

  dwatch_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .hit      (hit),
    .clr_req  (clr_req),
    .acc_pc   (acc_pc),
    .trap     (trap_o),
    .trap_sts (trap_sts_o),
    .fault_pc (fault_pc_o)
  );

  assign rd_en_o = dir_en.rd_en;
  assign wr_en_o = dir_en.wr_en;

  // R5
  no_en_no_trap_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en_o && !wr_en_o |=> !trap_o);

  // R3
  trap_needs_access_chk: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> $past(acc_valid));

  // R6
  pc_captured_chk: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> fault_pc_o == $past(acc_pc));
endmodule

// File: tb/sim_dwatch_top.sv
module sim_dwatch_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;

  // kind: 0 access, 1 cfg watch addr, 2 cfg control, 3 idle bus (valid low)
  typedef struct packed {
    logic [1:0]  kind;
    logic        sup;
    logic        wr;
    logic [31:0] data;
    logic [31:0] pc;
    logic        e_trap;
    logic        e_priv;
    logic        e_sts;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{2'd1, 1'b1, 1'b0, 32'h0000_1230, 32'h0,   1'b0, 1'b0, 1'b0}, // R2
    '{2'd0, 1'b0, 1'b0, 32'h0000_1230, 32'h100, 1'b0, 1'b0, 1'b0}, // R5 both off
    '{2'd2, 1'b1, 1'b0, 32'h0000_0001, 32'h0,   1'b0, 1'b0, 1'b0}, // R2 rd on
    '{2'd0, 1'b0, 1'b0, 32'h0000_1232, 32'h104, 1'b1, 1'b0, 1'b1}, // R3 byte in word
    '{2'd0, 1'b0, 1'b1, 32'h0000_1230, 32'h108, 1'b0, 1'b0, 1'b1}, // R5 store, wr off
    '{2'd0, 1'b0, 1'b0, 32'h0000_1234, 32'h10C, 1'b0, 1'b0, 1'b1}, // R5 next word
    '{2'd2, 1'b0, 1'b0, 32'h0000_0002, 32'h0,   1'b0, 1'b1, 1'b1}, // R8 user ctrl
    '{2'd0, 1'b0, 1'b1, 32'h0000_1231, 32'h10E, 1'b0, 1'b0, 1'b1}, // R8 still rd only
    '{2'd2, 1'b1, 1'b0, 32'h0000_0002, 32'h0,   1'b0, 1'b0, 1'b1}, // R2 wr only
    '{2'd0, 1'b0, 1'b1, 32'h0000_1233, 32'h110, 1'b1, 1'b0, 1'b1}, // R4
    '{2'd0, 1'b0, 1'b0, 32'h0000_1230, 32'h112, 1'b0, 1'b0, 1'b1}, // R5 load, rd off
    '{2'd3, 1'b0, 1'b1, 32'h0000_1230, 32'h113, 1'b0, 1'b0, 1'b1}, // R5 valid low
    '{2'd1, 1'b0, 1'b0, 32'hFFFF_0000, 32'h0,   1'b0, 1'b1, 1'b1}, // R8 user addr
    '{2'd0, 1'b0, 1'b1, 32'h0000_1230, 32'h114, 1'b1, 1'b0, 1'b1}  // R4 addr kept
  };

  logic clk = 1'b0;
  logic rst;
  logic cfg_we, cfg_sel, cfg_super;
  logic [31:0] cfg_wdata;
  logic acc_valid, acc_write;
  logic [31:0] acc_addr, acc_pc;
  logic [31:0] watch_addr_o, fault_pc_o;
  logic rd_en_o, wr_en_o, trap_o, trap_sts_o, priv_viol_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dwatch_top u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_super(cfg_super), .cfg_wdata(cfg_wdata), .acc_valid(acc_valid),
    .acc_write(acc_write), .acc_addr(acc_addr), .acc_pc(acc_pc),
    .watch_addr_o(watch_addr_o), .rd_en_o(rd_en_o), .wr_en_o(wr_en_o),
    .trap_o(trap_o), .trap_sts_o(trap_sts_o), .fault_pc_o(fault_pc_o),
    .priv_viol_o(priv_viol_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    cfg_we = 0; cfg_sel = 0; cfg_super = 0; cfg_wdata = '0;
    acc_valid = 0; acc_write = 0; acc_addr = '0; acc_pc = '0;
  endtask

  // drive on a falling edge, check at the next falling edge
  task automatic cfg(input logic sel, input logic sup, input logic [31:0] d);
    @(negedge clk);
    idle_inputs();
    cfg_we = 1; cfg_sel = sel; cfg_super = sup; cfg_wdata = d;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic acc(input logic w, input logic [31:0] a, input logic [31:0] pc);
    @(negedge clk);
    idle_inputs();
    acc_valid = 1; acc_write = w; acc_addr = a; acc_pc = pc;
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle_inputs();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1 watch", watch_addr_o, 32'h0);
    check("R1 en", {30'b0, rd_en_o, wr_en_o}, 32'h0);
    check("R1 trap/sts/priv", {29'b0, trap_o, trap_sts_o, priv_viol_o}, 32'h0);
    check("R1 fault_pc", fault_pc_o, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      idle_inputs();
      case (VEC[i].kind)
        2'd0, 2'd3: begin
          acc_valid = (VEC[i].kind == 2'd0);
          acc_write = VEC[i].wr; acc_addr = VEC[i].data; acc_pc = VEC[i].pc;
        end
        default: begin
          cfg_we = 1; cfg_super = VEC[i].sup; cfg_wdata = VEC[i].data;
          cfg_sel = (VEC[i].kind == 2'd2);
        end
      endcase
      @(negedge clk);
      idle_inputs();
      check($sformatf("R3/R4/R5 trap vec %0d", i), {31'b0, trap_o}, {31'b0, VEC[i].e_trap});
      check($sformatf("R8 priv vec %0d", i), {31'b0, priv_viol_o}, {31'b0, VEC[i].e_priv});
      check($sformatf("R7 sts vec %0d", i), {31'b0, trap_sts_o}, {31'b0, VEC[i].e_sts});
      if (VEC[i].e_trap)
        check($sformatf("R6 pc vec %0d", i), fault_pc_o, VEC[i].pc);
    end

    // R8: user writes left registers unchanged
    check("R8 watch kept", watch_addr_o, 32'h0000_1230);
    check("R8 en kept", {30'b0, rd_en_o, wr_en_o}, 32'h1);
    // R6: holds after trap falls
    @(negedge clk);
    check("R6 trap low", {31'b0, trap_o}, 32'h0);
    check("R6 pc held", fault_pc_o, 32'h114);

    // R8: user clear attempt does not clear status
    cfg(1'b1, 1'b0, 32'h0000_0006);
    check("R8 user clear", {31'b0, trap_sts_o}, 32'h1);
    check("R8 en kept 2", {30'b0, rd_en_o, wr_en_o}, 32'h1);
    // R7: supervisor clear, keep wr enable
    cfg(1'b1, 1'b1, 32'h0000_0006);
    check("R7 cleared", {31'b0, trap_sts_o}, 32'h0);
    check("R2 wr en", {30'b0, rd_en_o, wr_en_o}, 32'h1);

    // R7: trap and clear in the same cycle -> status set
    @(negedge clk);
    cfg_we = 1; cfg_sel = 1; cfg_super = 1; cfg_wdata = 32'h0000_0006;
    acc_valid = 1; acc_write = 1; acc_addr = 32'h0000_1230; acc_pc = 32'h200;
    @(negedge clk);
    idle_inputs();
    check("R7 set wins trap", {31'b0, trap_o}, 32'h1);
    check("R7 set wins sts", {31'b0, trap_sts_o}, 32'h1);
    check("R6 pc 200", fault_pc_o, 32'h200);

    // R9: enable write alongside matching load uses old enables (rd off)
    @(negedge clk);
    cfg_we = 1; cfg_sel = 1; cfg_super = 1; cfg_wdata = 32'h0000_0003;
    acc_valid = 1; acc_write = 0; acc_addr = 32'h0000_1230; acc_pc = 32'h204;
    @(negedge clk);
    idle_inputs();
    check("R9 old enable", {31'b0, trap_o}, 32'h0);
    check("R9 pc unchanged", fault_pc_o, 32'h200);
    check("R2 both en", {30'b0, rd_en_o, wr_en_o}, 32'h3);

    // R3: back-to-back loads give two pulses
    @(negedge clk);
    acc_valid = 1; acc_write = 0; acc_addr = 32'h0000_1231; acc_pc = 32'h300;
    @(negedge clk);
    check("R3 pulse 1", {31'b0, trap_o}, 32'h1);
    acc_pc = 32'h304;
    @(negedge clk);
    idle_inputs();
    check("R3 pulse 2", {31'b0, trap_o}, 32'h1);
    check("R6 pc 304", fault_pc_o, 32'h304);
    @(negedge clk);
    check("R3 single cycle", {31'b0, trap_o}, 32'h0);

    // R2: move watch address, old word no longer matches
    cfg(1'b0, 1'b1, 32'hABCD_0008);
    check("R2 new watch", watch_addr_o, 32'hABCD_0008);
    acc(1'b1, 32'h0000_1230, 32'h400);
    check("R5 old word", {31'b0, trap_o}, 32'h0);
    acc(1'b1, 32'hABCD_000B, 32'h404);
    check("R4 new word", {31'b0, trap_o}, 32'h1);

    // R1: reset mid-run
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    check("R1 re-reset", {watch_addr_o[3:0], rd_en_o, wr_en_o, trap_sts_o, 25'b0}, 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule